// File: doc/BRIEF.md
# Indirect Configuration Access Port

This block sits on the host side of a bridge and lets software reach the configuration space of devices behind it. It does this through two registers. Software first writes a selector register. That register names a bus, a device, a function and a register index, and it holds an enable flag. Software then reads or writes a data window. Each data-window access made while the enable flag is set becomes exactly one configuration transaction, sent on a request/response interface toward the downstream bus.

The block works out three things for each transaction:
- the bus number relative to a programmable base bus number;
- the transaction type, which is local when the relative bus is zero and forwarded otherwise;
- the 10-bit register index, built from the normal and the extended index fields.

It also turns the size and the low address bits of the host access into byte enables. The host handshake is valid/ready with wait states. The host raises `host_req_valid` and holds it, together with every request field, until it sees `host_req_ready` high at a clock edge. At that edge the access completes, and `host_rdata` is valid in the same cycle. Only one access is in progress at a time.

On the downstream side, `cfg_req_valid` stays high with stable fields until `cfg_req_ready` is seen. After that, a single-cycle `cfg_rsp_valid` pulse ends the transaction. If no pulse arrives within `RSP_TIMEOUT` cycles, the transaction ends on its own.

Top module: `cfg_access_port`

## Requirements
- R1: Bit 31 of the selector is the enable flag. While it is 0, a data-window access starts no downstream transaction and completes in its first cycle. A read then returns 0xFFFFFFFF and a write is dropped. Writing zero to the selector closes the window in this way.
- R2: The selector is at `host_req_sel`=0. It is written only by a word access (size 2, offset 0), which stores bits 31, 27:24 and 23:2. A read returns the stored value with bits 30:28 and 1:0 as zero. A selector access of any other size or offset leaves the selector unchanged, and a read of that kind returns 0xFFFFFFFF.
- R3: `cfg_req_reg` is the dword register index {selector[27:24], selector[7:2]}, so the full 4 KB space can be addressed.
- R4: `cfg_req_bus` = selector[23:16] − `first_bus`, modulo 256. `cfg_req_dev` is selector[15:11] and `cfg_req_func` is selector[10:8].
- R5: `cfg_req_type1` is 1 exactly when the relative bus number is non-zero.
- R6: Size codes are 0 = byte, 1 = halfword, 2 = word. The access covers lanes offset .. offset+size_bytes−1, and those lanes give `cfg_req_be`. Write data is lane-placed (the byte at offset k is on bits 8k+7:8k), and `cfg_req_wdata` keeps only the active lanes, with zeros elsewhere.
- R7: A data-window access is misaligned if it is a halfword at an odd offset, a word at a non-zero offset, or uses size code 3. A misaligned access starts no transaction and completes at once. A read of that kind returns 0xFFFFFFFF.
- R8: A completed read returns the response data on the active lanes and zero on the others. Every write completes with `host_rdata` = 0.
- R9: If no response arrives within `RSP_TIMEOUT` cycles after the request handshake, the access completes anyway. A read then returns all ones on the active lanes.
- R10: A data-window access that starts a transaction holds `host_req_ready` low until the cycle after the response, or the timeout. `cfg_req_valid` and its fields stay stable until `cfg_req_ready`. `host_req_ready` is never high without `host_req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| first_bus | input | 8 | Base bus number subtracted from the selector bus |
| host_req_valid | input | 1 | Host access present |
| host_req_ready | output | 1 | Access completes at this edge |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_sel | input | 1 | 0 = selector register, 1 = data window |
| host_req_offset | input | 2 | Byte offset inside the register |
| host_req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| host_req_wdata | input | 32 | Lane-placed write data |
| host_rdata | output | 32 | Read data, valid with host_req_ready |
| cfg_req_valid | output | 1 | Downstream request valid |
| cfg_req_ready | input | 1 | Downstream accepts request |
| cfg_req_write | output | 1 | Request is a write |
| cfg_req_type1 | output | 1 | Forwarded (type 1) transaction |
| cfg_req_bus | output | 8 | Relative bus number |
| cfg_req_dev | output | 5 | Device number |
| cfg_req_func | output | 3 | Function number |
| cfg_req_reg | output | 10 | Dword register index |
| cfg_req_be | output | 4 | Byte enables |
| cfg_req_wdata | output | 32 | Lane-masked write data |
| cfg_rsp_valid | input | 1 | Response pulse |
| cfg_rsp_rdata | input | 32 | Response read data |

## Verification
Word reads are issued with the selector bus equal to the base, above the base and below the base. Comparing them separates the type 0 and type 1 decisions and checks the modulo subtraction. Byte writes at each of the four offsets, followed by word, halfword and byte reads, show whether each byte enable lands on its own lane and whether read data is masked to the matching lanes. Misaligned sizes and offsets, a disabled window and byte-sized selector writes must complete at once with no downstream request. A stalled request handshake, a slow response and a silent target separate the hold-until-accepted behaviour from the timeout path.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FN_W   = 3;
  localparam int REGN_W = 10;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } eng_state_e;

  typedef struct packed {
    logic              type1;
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FN_W-1:0]   func;
    logic [REGN_W-1:0] regn;
  } cfg_target_t;

  // Expand per-lane enables into a bit mask over the data word.
  function automatic logic [DATA_W-1:0] lanes_to_mask(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/cfg_sel_reg.sv
module cfg_sel_reg
  import cfg_port_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEEP_MASK = 32'h8FFF_FFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] sel_q
);
  // Only the implemented bits are stored; the rest read back as zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (wr_en)  sel_q <= wr_data & KEEP_MASK;
  end

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (sel_q == ($past(wr_data) & KEEP_MASK)));
endmodule

// File: rtl/cfg_lane_decode.sv
module cfg_lane_decode
  import cfg_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       size,
  input  logic [1:0]       offset,
  output logic             legal,
  output logic [LANES-1:0] be
);
  logic [2:0] nbytes;
  logic [2:0] first;

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: begin nbytes = 3'd1; legal = 1'b1;            end
      SZ_HALF: begin nbytes = 3'd2; legal = ~offset[0];      end
      SZ_WORD: begin nbytes = 3'd4; legal = (offset == 2'd0); end
      default: begin nbytes = 3'd0; legal = 1'b0;            end
    endcase
  end

  assign first = {1'b0, offset};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[i] = legal && (first <= 3'(i)) && (3'(i) < (first + nbytes));
  end

  p_byte_one_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (size == 2'd0) |-> ($countones(be) == 1));
  p_half_two_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (size == 2'd1 && legal) |-> ($countones(be) == 2));
  p_illegal_no_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |-> (be == '0));
endmodule

// File: rtl/cfg_xact_engine.sv
module cfg_xact_engine
  import cfg_port_pkg::*;
#(
  parameter int RSP_TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  cfg_target_t       start_tgt,
  input  logic [LANES-1:0]  start_be,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              idle,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic              cfg_req_write,
  output logic              cfg_req_type1,
  output logic [BUS_W-1:0]  cfg_req_bus,
  output logic [DEV_W-1:0]  cfg_req_dev,
  output logic [FN_W-1:0]   cfg_req_func,
  output logic [REGN_W-1:0] cfg_req_reg,
  output logic [LANES-1:0]  cfg_req_be,
  output logic [DATA_W-1:0] cfg_req_wdata,
  input  logic              cfg_rsp_valid,
  input  logic [DATA_W-1:0] cfg_rsp_rdata
);
  localparam int TO_CYC = (RSP_TIMEOUT < 1) ? 1 : RSP_TIMEOUT;
  localparam int CNT_W  = $clog2(TO_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TO_CYC - 1);

  eng_state_e        state;
  cfg_target_t       tgt_q;
  logic              write_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] result_q;
  logic [CNT_W-1:0]  wait_cnt;
  logic [DATA_W-1:0] mask_q;

  assign mask_q = lanes_to_mask(be_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tgt_q    <= '0;
      write_q  <= 1'b0;
      be_q     <= '0;
      wdata_q  <= '0;
      result_q <= '0;
      wait_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          tgt_q   <= start_tgt;
          write_q <= start_write;
          be_q    <= start_be;
          wdata_q <= start_wdata & lanes_to_mask(start_be);
          state   <= ST_REQ;
        end
        ST_REQ: if (cfg_req_ready) begin
          wait_cnt <= '0;
          state    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cfg_rsp_valid) begin
            result_q <= write_q ? '0 : (cfg_rsp_rdata & mask_q);
            state    <= ST_DONE;
          end else if (wait_cnt == CNT_LAST) begin
            result_q <= write_q ? '0 : mask_q;
            state    <= ST_DONE;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle          = (state == ST_IDLE);
  assign done          = (state == ST_DONE);
  assign result        = result_q;
  assign cfg_req_valid = (state == ST_REQ);
  assign cfg_req_write = write_q;
  assign cfg_req_type1 = tgt_q.type1;
  assign cfg_req_bus   = tgt_q.bus;
  assign cfg_req_dev   = tgt_q.dev;
  assign cfg_req_func  = tgt_q.func;
  assign cfg_req_reg   = tgt_q.regn;
  assign cfg_req_be    = be_q;
  assign cfg_req_wdata = wdata_q;

  p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && !cfg_req_ready) |=>
      (cfg_req_valid && $stable(cfg_req_bus) && $stable(cfg_req_reg) &&
       $stable(cfg_req_be) && $stable(cfg_req_wdata) && $stable(cfg_req_write)));
  p_type_follows_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (cfg_req_type1 == (cfg_req_bus != '0)));
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> idle);
  p_req_has_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (cfg_req_be != '0));
endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
  import cfg_port_pkg::*;
#(
  parameter int RSP_TIMEOUT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  first_bus,
  input  logic        host_req_valid,
  output logic        host_req_ready,
  input  logic        host_req_write,
  input  logic        host_req_sel,
  input  logic [1:0]  host_req_offset,
  input  logic [1:0]  host_req_size,
  input  logic [31:0] host_req_wdata,
  output logic [31:0] host_rdata,
  output logic        cfg_req_valid,
  input  logic        cfg_req_ready,
  output logic        cfg_req_write,
  output logic        cfg_req_type1,
  output logic [7:0]  cfg_req_bus,
  output logic [4:0]  cfg_req_dev,
  output logic [2:0]  cfg_req_func,
  output logic [9:0]  cfg_req_reg,
  output logic [3:0]  cfg_req_be,
  output logic [31:0] cfg_req_wdata,
  input  logic        cfg_rsp_valid,
  input  logic [31:0] cfg_rsp_rdata
);
  logic [DATA_W-1:0] sel_q;
  logic              sel_wr;
  logic              win_legal;
  logic [LANES-1:0]  win_be;
  logic              eng_idle;
  logic              eng_done;
  logic [DATA_W-1:0] eng_result;
  logic              launch;
  logic              word_at_zero;
  logic              win_enabled;
  cfg_target_t       tgt;
  logic [BUS_W-1:0]  rel_bus;

  assign word_at_zero = (host_req_size == 2'd2) && (host_req_offset == 2'd0);
  assign win_enabled  = sel_q[31];

  // Selector is written only by an aligned word while nothing is in flight.
  assign sel_wr = host_req_valid && !host_req_sel && host_req_write &&
                  word_at_zero && eng_idle;

  cfg_sel_reg u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sel_wr),
    .wr_data (host_req_wdata),
    .sel_q   (sel_q)
  );

  cfg_lane_decode u_lanes (
    .clk    (clk),
    .rst_n  (rst_n),
    .size   (host_req_size),
    .offset (host_req_offset),
    .legal  (win_legal),
    .be     (win_be)
  );

  assign rel_bus    = sel_q[23:16] - first_bus;
  assign tgt.type1  = (rel_bus != '0);
  assign tgt.bus    = rel_bus;
  assign tgt.dev    = sel_q[15:11];
  assign tgt.func   = sel_q[10:8];
  assign tgt.regn   = {sel_q[27:24], sel_q[7:2]};

  assign launch = host_req_valid && host_req_sel && win_enabled && win_legal && eng_idle;

  cfg_xact_engine #(.RSP_TIMEOUT(RSP_TIMEOUT)) u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (launch),
    .start_write   (host_req_write),
    .start_tgt     (tgt),
    .start_be      (win_be),
    .start_wdata   (host_req_wdata),
    .idle          (eng_idle),
    .done          (eng_done),
    .result        (eng_result),
    .cfg_req_valid (cfg_req_valid),
    .cfg_req_ready (cfg_req_ready),
    .cfg_req_write (cfg_req_write),
    .cfg_req_type1 (cfg_req_type1),
    .cfg_req_bus   (cfg_req_bus),
    .cfg_req_dev   (cfg_req_dev),
    .cfg_req_func  (cfg_req_func),
    .cfg_req_reg   (cfg_req_reg),
    .cfg_req_be    (cfg_req_be),
    .cfg_req_wdata (cfg_req_wdata),
    .cfg_rsp_valid (cfg_rsp_valid),
    .cfg_rsp_rdata (cfg_rsp_rdata)
  );

  // Accesses that need no downstream traffic finish in their first cycle.
  always_comb begin
    host_req_ready = 1'b0;
    host_rdata     = '0;
    if (eng_done) begin
      host_req_ready = host_req_valid;
      host_rdata     = eng_result;
    end else if (eng_idle && host_req_valid && !launch) begin
      host_req_ready = 1'b1;
      if (host_req_write)        host_rdata = '0;
      else if (!host_req_sel && word_at_zero) host_rdata = sel_q;
      else                       host_rdata = '1;
    end
  end

  p_window_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> sel_q[31]);
  p_ready_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_req_ready |-> host_req_valid);
  p_misaligned_read_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req_valid && host_req_sel && !win_legal && !host_req_write && eng_idle)
      |-> (host_req_ready && host_rdata == 32'hFFFF_FFFF));
  p_closed_no_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_idle && !sel_q[31]) |=> !cfg_req_valid);
endmodule

// File: tb/cfg_access_port_tb.sv
module cfg_access_port_tb;
  localparam int TO = 16;
  localparam logic [31:0] KEEP = 32'h8FFF_FFFC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  first_bus = 8'h00;
  logic        host_req_valid = 1'b0;
  logic        host_req_ready;
  logic        host_req_write = 1'b0;
  logic        host_req_sel = 1'b0;
  logic [1:0]  host_req_offset = 2'd0;
  logic [1:0]  host_req_size = 2'd0;
  logic [31:0] host_req_wdata = '0;
  logic [31:0] host_rdata;
  logic        cfg_req_valid;
  logic        cfg_req_ready = 1'b0;
  logic        cfg_req_write;
  logic        cfg_req_type1;
  logic [7:0]  cfg_req_bus;
  logic [4:0]  cfg_req_dev;
  logic [2:0]  cfg_req_func;
  logic [9:0]  cfg_req_reg;
  logic [3:0]  cfg_req_be;
  logic [31:0] cfg_req_wdata;
  logic        cfg_rsp_valid = 1'b0;
  logic [31:0] cfg_rsp_rdata = '0;

  always #2 clk = ~clk;

  cfg_access_port #(.RSP_TIMEOUT(TO)) u_dut (.*);

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int ready_delay = 0;
  int rsp_delay = 0;
  bit silent = 0;
  logic [31:0] m_sel = '0;
  logic [63:0] exp_q[$];
  logic [31:0] space [int];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] space_rd(input int key);
    if (space.exists(key)) return space[key];
    return 32'h5A00_0000 ^ key;
  endfunction

  function automatic logic [31:0] mask_of(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [31:0] mk_sel(input bit en, input logic [3:0] ext, input logic [7:0] bus,
                                         input logic [4:0] dev, input logic [2:0] fn, input logic [5:0] r);
    return {en, 3'b000, ext, bus, dev, fn, r, 2'b00};
  endfunction

  // Responder: accepts after ready_delay, answers after rsp_delay unless silent.
  initial begin
    forever begin
      @(negedge clk);
      if (cfg_req_valid && !finished) begin
        int key;
        logic [31:0] word;
        repeat (ready_delay) @(posedge clk);
        @(posedge clk); #1;
        cfg_req_ready = 1'b1;
        key = int'({cfg_req_type1, cfg_req_bus, cfg_req_dev, cfg_req_func, cfg_req_reg});
        word = space_rd(key);
        if (cfg_req_write) begin
          for (int i = 0; i < 4; i++) if (cfg_req_be[i]) word[8*i +: 8] = cfg_req_wdata[8*i +: 8];
          space[key] = word;
        end
        @(posedge clk); #1;
        cfg_req_ready = 1'b0;
        if (!silent) begin
          repeat (rsp_delay) @(posedge clk);
          #0;
          cfg_rsp_valid = 1'b1;
          cfg_rsp_rdata = word;
          @(posedge clk); #1;
          cfg_rsp_valid = 1'b0;
          cfg_rsp_rdata = '0;
        end
      end
    end
  end

  // Per-clock monitor: every handshake must match the model's next entry.
  logic        prev_stall = 1'b0;
  logic [63:0] prev_pack = '0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [63:0] pack;
      pack = {cfg_req_write, cfg_req_type1, cfg_req_bus, cfg_req_dev, cfg_req_func,
              cfg_req_reg, cfg_req_be, cfg_req_wdata};
      if (prev_stall) chk(cfg_req_valid && pack == prev_pack, "R10 request held", pack, prev_pack);
      if (cfg_req_valid && cfg_req_ready) begin
        if (exp_q.size() == 0) chk(0, "R1 unexpected transaction", pack, 64'h0);
        else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk(pack == e, "R3/R4/R5/R6 request fields", pack, e);
        end
      end
      prev_stall = cfg_req_valid && !cfg_req_ready;
      prev_pack  = pack;
    end
  end

  task automatic host_do(input bit wr, input bit sel, input logic [1:0] off, input logic [1:0] sz,
                         input logic [31:0] wd, input string req);
    bit legal, launched;
    logic [3:0] be;
    logic [31:0] exp_rd, got;
    logic [7:0] rel;
    int key, waited;
    be = '0;
    launched = 0;
    if (!sel) begin
      legal = (sz == 2'd2) && (off == 2'd0);
      exp_rd = wr ? 32'h0 : (legal ? m_sel : 32'hFFFF_FFFF);
      if (wr && legal) m_sel = wd & KEEP;
    end else begin
      int n;
      n = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
      legal = (sz == 0) || (sz == 1 && !off[0]) || (sz == 2 && off == 0);
      if (legal) for (int i = 0; i < 4; i++) be[i] = (i >= off) && (i < off + n);
      if (legal && m_sel[31]) begin
        launched = 1;
        rel = m_sel[23:16] - first_bus;
        key = int'({rel != 8'h0, rel, m_sel[15:11], m_sel[10:8], m_sel[27:24], m_sel[7:2]});
        exp_q.push_back({wr, rel != 8'h0, rel, m_sel[15:11], m_sel[10:8], m_sel[27:24], m_sel[7:2],
                         be, wd & mask_of(be)});
        exp_rd = wr ? 32'h0 : (silent ? mask_of(be) : (space_rd(key) & mask_of(be)));
      end else begin
        exp_rd = wr ? 32'h0 : 32'hFFFF_FFFF;
      end
    end
    @(posedge clk); #1;
    host_req_valid = 1'b1; host_req_write = wr; host_req_sel = sel;
    host_req_offset = off; host_req_size = sz; host_req_wdata = wd;
    waited = 0;
    forever begin
      @(negedge clk);
      if (host_req_ready) break;
      waited++;
    end
    got = host_rdata;
    @(posedge clk); #1;
    host_req_valid = 1'b0;
    chk(got == exp_rd, {req, " read data"}, got, exp_rd);
    if (launched) begin
      chk(exp_q.size() == 0, "R10 completes after transaction", exp_q.size(), 0);
      if (silent) chk(waited >= TO, "R9 timeout wait", waited, TO);
    end else begin
      chk(waited == 0, {req, " immediate completion"}, waited, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!cfg_req_valid && !host_req_ready, "R10 reset idle", {cfg_req_valid, host_req_ready}, 0);

    // R2 reset value, R1 closed window
    host_do(0, 0, 2'd0, 2'd2, 0, "R2 selector reset");
    host_do(0, 1, 2'd0, 2'd2, 0, "R1 closed read");
    host_do(1, 1, 2'd0, 2'd2, 32'h1234_5678, "R1 closed write");

    // R2 masking and ignored narrow writes
    host_do(1, 0, 2'd0, 2'd2, 32'hFFFF_FFFF, "R2 selector write");
    host_do(0, 0, 2'd0, 2'd2, 0, "R2 selector readback");
    host_do(1, 0, 2'd0, 2'd0, 32'h0, "R2 byte write ignored");
    host_do(0, 0, 2'd0, 2'd2, 0, "R2 selector unchanged");
    host_do(0, 0, 2'd2, 2'd1, 0, "R2 narrow read ones");

    // R4/R5 type 0 at the base bus
    first_bus = 8'h10;
    host_do(1, 0, 2'd0, 2'd2, mk_sel(1, 4'h0, 8'h10, 5'd3, 3'd1, 6'd5), "R4 set");
    host_do(0, 1, 2'd0, 2'd2, 0, "R5 type0 word read R8");
    // R5 type 1 and R3 extended index
    host_do(1, 0, 2'd0, 2'd2, mk_sel(1, 4'hA, 8'h12, 5'd31, 3'd7, 6'd63), "R3 set");
    host_do(0, 1, 2'd0, 2'd2, 0, "R3 extended type1 read");
    // R4 bus below base wraps
    host_do(1, 0, 2'd0, 2'd2, mk_sel(1, 4'h1, 8'h05, 5'd9, 3'd2, 6'd1), "R4 set wrap");
    host_do(0, 1, 2'd0, 2'd2, 0, "R4 wrapped bus read");

    // R6 byte lanes, then R8 merged reads
    for (int k = 0; k < 4; k++)
      host_do(1, 1, 2'(k), 2'd0, 32'h11 * (k + 1) << (8 * k), "R6 byte write");
    host_do(0, 1, 2'd0, 2'd2, 0, "R8 merged word");
    host_do(0, 1, 2'd0, 2'd1, 0, "R8 low half");
    host_do(0, 1, 2'd2, 2'd1, 0, "R8 high half");
    host_do(0, 1, 2'd3, 2'd0, 0, "R8 top byte");
    host_do(1, 1, 2'd2, 2'd1, 32'hBEEF_0000, "R6 half write");
    host_do(0, 1, 2'd0, 2'd2, 0, "R6 after half write");

    // R7 misaligned
    host_do(0, 1, 2'd1, 2'd1, 0, "R7 odd half read");
    host_do(1, 1, 2'd2, 2'd2, 32'hDEAD_BEEF, "R7 offset word write");
    host_do(0, 1, 2'd0, 2'd3, 0, "R7 reserved size");
    host_do(0, 1, 2'd0, 2'd2, 0, "R7 data untouched");

    // R10 back-pressure and slow response
    ready_delay = 3; rsp_delay = 5;
    host_do(1, 1, 2'd1, 2'd0, 32'h0000_7700, "R10 slow write");
    host_do(0, 1, 2'd0, 2'd2, 0, "R10 slow read");
    ready_delay = 0; rsp_delay = 0;

    // R9 silent target
    silent = 1;
    host_do(0, 1, 2'd2, 2'd1, 0, "R9 timeout half read");
    host_do(1, 1, 2'd0, 2'd2, 32'h0, "R9 timeout write");
    silent = 0;

    // R1 closing the window with zero
    host_do(1, 0, 2'd0, 2'd2, 32'h0, "R1 close");
    host_do(0, 1, 2'd0, 2'd2, 0, "R1 reclosed read");
    host_do(1, 1, 2'd0, 2'd0, 32'h55, "R1 reclosed write");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R1 no stray transactions", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule